// File: doc/BRIEF.md
# Character LCD Byte Writer

This block lets a host write whole bytes to a character LCD controller that has only a 4-bit data bus. The host places a byte and a register-select bit on the inputs and pulses a strobe for one clock cycle. The block latches both on that edge. It then sends the byte as two nibbles, each with its own enable pulse, and holds `busy` high until the display has had time to execute the byte.

After reset the block runs the display's power-on initialisation on its own. It waits for power to settle, sends the wake-up nibble three times with waits between them, and then sends the nibble that switches the display to 4-bit mode. It follows with four configuration commands. `busy` stays high for the whole sequence. A host byte that is strobed while the block is busy, including during initialisation, is held one deep and written as soon as the current activity ends.

All timing is set by parameters counted in clock cycles: the data setup before enable, the enable width, the hold after enable, the power-on wait, the two wake-up waits and the per-byte settle time.

Top module: `lcd_byte_writer`

## Requirements
- R1: From reset, `busy` is high and `lcd_en` is low. The block first sends the nibbles 0x3, 0x3, 0x3 and 0x2 as single pulses. It then sends the bytes 0x28 (0x20 when TWO_LINE=0), 0x0C, 0x01 and 0x06 as nibble pairs. Every one of these carries `lcd_rs`=0. `busy` falls only after the last of them.
- R2: A strobe while `busy` is low latches `wr_data` and `wr_rs` on that clock edge. Changes to those inputs after that edge have no effect on the byte that is sent.
- R3: `busy` is high from the edge after an accepted strobe. It stays high for exactly 2*(SETUP_CYC+PULSE_CYC+HOLD_CYC+2)+SETTLE_CYC+1 cycles, which covers both nibbles and the settle time, and then returns low. `lcd_en` is never high while `busy` is low.
- R4: Each byte is sent as exactly two enable pulses: bits [7:4] on `lcd_db` during the first pulse and bits [3:0] during the second.
- R5: `lcd_rs` carries the latched select bit for both nibbles of a host byte. A value of 0 addresses the command register and 1 addresses the data register.
- R6: `lcd_db` and `lcd_rs` settle at least SETUP_CYC cycles (SETUP_CYC ≥ 2) before `lcd_en` rises. They do not change while `lcd_en` is high. `lcd_en` stays high for exactly PULSE_CYC cycles.
- R7: `lcd_rw` is 0 at all times.
- R8: A strobe that arrives while `busy` is high is held, one deep. Its byte is written with its own select bit right after the current activity, which includes the whole initialisation. `busy` stays high until that byte has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data | input | 8 | Byte to write |
| wr_rs | input | 1 | Register select for the byte: 0 = command, 1 = data |
| wr_strobe | input | 1 | One-cycle write request |
| busy | output | 1 | High while a write, the settle time or the initialisation is under way |
| lcd_db | output | 4 | Display nibble bus |
| lcd_en | output | 1 | Display enable strobe; the display samples on the falling edge |
| lcd_rs | output | 1 | Display register select |
| lcd_rw | output | 1 | Display read/write, tied to write |

## Verification
The inline properties watch every cycle for three things. They check that `busy` rises after an accepted strobe and stays high during initialisation. They check that enable never pulses while the block reports idle. They also check that the bus holds steady while enable is high and has been set up at least two cycles before each rising edge. Several things can only be shown by the directed scenarios, using a falling-edge nibble sampler in the bench. These are the order and content of the reassembled bytes, the exact initialisation nibble list, the select bit on each nibble, the exact length of the busy window, and the deferred write of a byte strobed during initialisation.

// File: rtl/lcd_wr_pkg.sv
package lcd_wr_pkg;

   localparam int INIT_STEPS = 8;
   localparam int INIT_IDX_W = $clog2(INIT_STEPS);

   typedef enum logic [1:0] {
      WSEL_LONG  = 2'd0,
      WSEL_SHORT = 2'd1,
      WSEL_CMD   = 2'd2
   } wait_sel_t;

   typedef struct packed {
      logic      nib_only;
      logic [7:0] code;
      wait_sel_t  wsel;
   } init_step_t;

   typedef enum logic [2:0] {
      SEQ_POR    = 3'd0,
      SEQ_IDLE   = 3'd1,
      SEQ_HI_GO  = 3'd2,
      SEQ_HI_WT  = 3'd3,
      SEQ_LO_GO  = 3'd4,
      SEQ_LO_WT  = 3'd5,
      SEQ_WAIT   = 3'd6
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_PULSE = 2'd2,
      PH_HOLD  = 2'd3
   } tx_phase_t;

endpackage

// File: rtl/lcd_init_table.sv
module lcd_init_table
   import lcd_wr_pkg::*;
#(
   parameter int TWO_LINE = 1
) (
   input  logic [INIT_IDX_W-1:0] idx,
   output init_step_t            entry
);

   logic [7:0] fset_code;

   generate
      if (TWO_LINE != 0) begin : g_two_line
         assign fset_code = 8'h28;
      end else begin : g_one_line
         assign fset_code = 8'h20;
      end
   endgenerate

   always_comb begin
      case (idx)
         3'd0:    entry = '{nib_only: 1'b1, code: 8'h30, wsel: WSEL_LONG};
         3'd1:    entry = '{nib_only: 1'b1, code: 8'h30, wsel: WSEL_SHORT};
         3'd2:    entry = '{nib_only: 1'b1, code: 8'h30, wsel: WSEL_SHORT};
         3'd3:    entry = '{nib_only: 1'b1, code: 8'h20, wsel: WSEL_SHORT};
         3'd4:    entry = '{nib_only: 1'b0, code: fset_code, wsel: WSEL_CMD};
         3'd5:    entry = '{nib_only: 1'b0, code: 8'h0C, wsel: WSEL_CMD};
         3'd6:    entry = '{nib_only: 1'b0, code: 8'h01, wsel: WSEL_CMD};
         default: entry = '{nib_only: 1'b0, code: 8'h06, wsel: WSEL_CMD};
      endcase
   end

endmodule

// File: rtl/lcd_wait_timer.sv
module lcd_wait_timer #(
   parameter int W         = 8,
   parameter int RESET_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= W'(RESET_VAL);
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/lcd_nibble_tx.sv
module lcd_nibble_tx
   import lcd_wr_pkg::*;
#(
   parameter int SETUP_CYC = 2,
   parameter int PULSE_CYC = 24,
   parameter int HOLD_CYC  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [3:0] nib,
   input  logic       rs,
   output logic [3:0] db_o,
   output logic       rs_o,
   output logic       en_o,
   output logic       done
);

   localparam int MAX_PH = (SETUP_CYC > PULSE_CYC) ?
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                           ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
   localparam int CW = (MAX_PH < 2) ? 1 : $clog2(MAX_PH);

   generate
      if (SETUP_CYC < 2) begin : g_bad_setup
         $error("SETUP_CYC must be at least 2");
      end
      if (PULSE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_pulse
         $error("PULSE_CYC and HOLD_CYC must be at least 1");
      end
   endgenerate

   tx_phase_t     ph_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         db_o  <= '0;
         rs_o  <= 1'b0;
         en_o  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  db_o  <= nib;
                  rs_o  <= rs;
                  cnt_q <= CW'(SETUP_CYC - 1);
                  ph_q  <= PH_SETUP;
               end
            end
            PH_SETUP: begin
               if (cnt_q == '0) begin
                  en_o  <= 1'b1;
                  cnt_q <= CW'(PULSE_CYC - 1);
                  ph_q  <= PH_PULSE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_PULSE: begin
               if (cnt_q == '0) begin
                  en_o  <= 1'b0;
                  cnt_q <= CW'(HOLD_CYC - 1);
                  ph_q  <= PH_HOLD;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (cnt_q == '0) begin
                  done <= 1'b1;
                  ph_q <= PH_IDLE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         endcase
      end
   end

   // checker support: cycles since the bus was last loaded, saturating
   logic [1:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   age_q <= 2'd3;
      else if (start && ph_q == PH_IDLE) age_q <= 2'd0;
      else if (age_q != 2'd3)       age_q <= age_q + 2'd1;
   end

   assert_setup_before_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o) |-> (age_q >= 2'd2))
      else $error("enable rose with less than two cycles of setup");

   assert_bus_stable_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o && $past(en_o)) |-> ($stable(db_o) && $stable(rs_o)))
      else $error("bus changed while enable high");

endmodule

// File: rtl/lcd_byte_writer.sv
module lcd_byte_writer
   import lcd_wr_pkg::*;
#(
   parameter int SETUP_CYC  = 2,
   parameter int PULSE_CYC  = 24,
   parameter int HOLD_CYC   = 2,
   parameter int POR_WAIT   = 1_500_000,
   parameter int INIT_LONG  = 410_000,
   parameter int INIT_SHORT = 10_000,
   parameter int SETTLE_CYC = 160_000,
   parameter int TWO_LINE   = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] wr_data,
   input  logic       wr_rs,
   input  logic       wr_strobe,
   output logic       busy,
   output logic [3:0] lcd_db,
   output logic       lcd_en,
   output logic       lcd_rs,
   output logic       lcd_rw
);

   localparam int MAX_A   = (POR_WAIT > INIT_LONG) ? POR_WAIT : INIT_LONG;
   localparam int MAX_B   = (INIT_SHORT > SETTLE_CYC) ? INIT_SHORT : SETTLE_CYC;
   localparam int MAX_W   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int TW      = $clog2(MAX_W + 1);

   generate
      if (INIT_LONG < 1 || INIT_SHORT < 1 || SETTLE_CYC < 1) begin : g_bad_wait
         $error("wait parameters must be at least 1");
      end
   endgenerate

   seq_state_t            state_q;
   logic [INIT_IDX_W-1:0] step_q;
   logic                  init_done_q;
   logic [7:0]            cur_code_q;
   logic                  cur_rs_q;
   logic                  cur_nib_q;
   wait_sel_t             cur_wsel_q;
   logic                  pend_v_q;
   logic [7:0]            pend_code_q;
   logic                  pend_rs_q;

   logic [INIT_IDX_W-1:0] tbl_idx;
   init_step_t            tbl_entry;
   logic                  step_last;
   logic                  tx_start, tx_done;
   logic [3:0]            tx_nib;
   logic                  tmr_load, tmr_zero;
   logic [TW-1:0]         tmr_val;

   assign tbl_idx   = (state_q == SEQ_WAIT) ? step_q + 1'b1 : step_q;
   assign step_last = (step_q == INIT_IDX_W'(INIT_STEPS - 1));

   lcd_init_table #(.TWO_LINE(TWO_LINE)) init_tbl_i (
      .idx   (tbl_idx),
      .entry (tbl_entry)
   );

   assign tx_start = (state_q == SEQ_HI_GO) || (state_q == SEQ_LO_GO);
   assign tx_nib   = (state_q == SEQ_HI_GO) ? cur_code_q[7:4] : cur_code_q[3:0];

   lcd_nibble_tx #(
      .SETUP_CYC (SETUP_CYC),
      .PULSE_CYC (PULSE_CYC),
      .HOLD_CYC  (HOLD_CYC)
   ) nib_tx_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tx_start),
      .nib   (tx_nib),
      .rs    (cur_rs_q),
      .db_o  (lcd_db),
      .rs_o  (lcd_rs),
      .en_o  (lcd_en),
      .done  (tx_done)
   );

   assign tmr_load = tx_done &&
                     (((state_q == SEQ_HI_WT) && cur_nib_q) || (state_q == SEQ_LO_WT));

   always_comb begin
      case (cur_wsel_q)
         WSEL_LONG:  tmr_val = TW'(INIT_LONG);
         WSEL_SHORT: tmr_val = TW'(INIT_SHORT);
         default:    tmr_val = TW'(SETTLE_CYC);
      endcase
   end

   lcd_wait_timer #(.W(TW), .RESET_VAL(POR_WAIT)) wait_tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SEQ_POR;
         step_q      <= '0;
         init_done_q <= 1'b0;
         cur_code_q  <= '0;
         cur_rs_q    <= 1'b0;
         cur_nib_q   <= 1'b0;
         cur_wsel_q  <= WSEL_CMD;
         pend_v_q    <= 1'b0;
         pend_code_q <= '0;
         pend_rs_q   <= 1'b0;
      end else begin
         if (wr_strobe && state_q != SEQ_IDLE && !pend_v_q) begin
            pend_v_q    <= 1'b1;
            pend_code_q <= wr_data;
            pend_rs_q   <= wr_rs;
         end
         case (state_q)
            SEQ_POR: begin
               if (tmr_zero) begin
                  cur_code_q <= tbl_entry.code;
                  cur_rs_q   <= 1'b0;
                  cur_nib_q  <= tbl_entry.nib_only;
                  cur_wsel_q <= tbl_entry.wsel;
                  state_q    <= SEQ_HI_GO;
               end
            end
            SEQ_IDLE: begin
               if (pend_v_q) begin
                  cur_code_q <= pend_code_q;
                  cur_rs_q   <= pend_rs_q;
                  cur_nib_q  <= 1'b0;
                  cur_wsel_q <= WSEL_CMD;
                  pend_v_q   <= 1'b0;
                  state_q    <= SEQ_HI_GO;
               end else if (wr_strobe) begin
                  cur_code_q <= wr_data;
                  cur_rs_q   <= wr_rs;
                  cur_nib_q  <= 1'b0;
                  cur_wsel_q <= WSEL_CMD;
                  state_q    <= SEQ_HI_GO;
               end
            end
            SEQ_HI_GO: state_q <= SEQ_HI_WT;
            SEQ_HI_WT: begin
               if (tx_done) state_q <= cur_nib_q ? SEQ_WAIT : SEQ_LO_GO;
            end
            SEQ_LO_GO: state_q <= SEQ_LO_WT;
            SEQ_LO_WT: begin
               if (tx_done) state_q <= SEQ_WAIT;
            end
            default: begin
               if (tmr_zero) begin
                  if (!init_done_q && !step_last) begin
                     step_q     <= step_q + 1'b1;
                     cur_code_q <= tbl_entry.code;
                     cur_rs_q   <= 1'b0;
                     cur_nib_q  <= tbl_entry.nib_only;
                     cur_wsel_q <= tbl_entry.wsel;
                     state_q    <= SEQ_HI_GO;
                  end else begin
                     init_done_q <= 1'b1;
                     if (pend_v_q) begin
                        cur_code_q <= pend_code_q;
                        cur_rs_q   <= pend_rs_q;
                        cur_nib_q  <= 1'b0;
                        cur_wsel_q <= WSEL_CMD;
                        pend_v_q   <= 1'b0;
                        state_q    <= SEQ_HI_GO;
                     end else begin
                        state_q <= SEQ_IDLE;
                     end
                  end
               end
            end
         endcase
      end
   end

   assign busy   = (state_q != SEQ_IDLE) || pend_v_q;
   assign lcd_rw = 1'b0;

   assert_busy_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && !busy) |=> busy)
      else $error("busy did not rise after accepted strobe");

   assert_en_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lcd_en |-> busy)
      else $error("enable pulsed while idle");

   assert_busy_in_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done_q |-> busy)
      else $error("busy low before initialisation completed");

endmodule

// File: tb/lcd_byte_writer_tb.sv
module lcd_byte_writer_tb_top;

   localparam int SETUP  = 2;
   localparam int PULSE  = 3;
   localparam int HOLD   = 2;
   localparam int SETTLE = 30;
   localparam int BUSY_EXP = 2 * (SETUP + PULSE + HOLD + 2) + SETTLE + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_rs = 1'b0;
   logic       wr_strobe = 1'b0;
   logic       busy;
   logic [3:0] lcd_db;
   logic       lcd_en, lcd_rs, lcd_rw;

   always #5 clk = ~clk;

   lcd_byte_writer #(
      .SETUP_CYC (SETUP), .PULSE_CYC (PULSE), .HOLD_CYC (HOLD),
      .POR_WAIT (50), .INIT_LONG (40), .INIT_SHORT (20),
      .SETTLE_CYC (SETTLE), .TWO_LINE (1)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .wr_data (wr_data), .wr_rs (wr_rs),
      .wr_strobe (wr_strobe), .busy (busy), .lcd_db (lcd_db),
      .lcd_en (lcd_en), .lcd_rs (lcd_rs), .lcd_rw (lcd_rw)
   );

   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // display model: samples the nibble bus when enable falls
   logic [3:0] nib_log [0:63];
   logic       rs_log  [0:63];
   int         nib_cnt = 0;
   logic       en_prev = 1'b0;
   logic [4:0] bus_prev = '0;
   int         stable = 0;
   int         hi_w = 0;
   int         min_setup = 999;
   int         min_hi = 999;
   int         max_hi = 0;
   int         chg_hi = 0;
   int         rw_bad = 0;

   always @(negedge clk) begin
      if (lcd_rw !== 1'b0) rw_bad++;
      if ({lcd_rs, lcd_db} == bus_prev) stable++;
      else stable = 1;
      if (lcd_en && en_prev && ({lcd_rs, lcd_db} != bus_prev)) chg_hi++;
      if (lcd_en && !en_prev) begin
         if (stable < min_setup) min_setup = stable;
         hi_w = 0;
      end
      if (lcd_en) hi_w++;
      if (!lcd_en && en_prev) begin
         if (hi_w < min_hi) min_hi = hi_w;
         if (hi_w > max_hi) max_hi = hi_w;
         if (nib_cnt < 64) begin
            nib_log[nib_cnt] = lcd_db;
            rs_log[nib_cnt]  = lcd_rs;
         end
         nib_cnt++;
      end
      en_prev  = lcd_en;
      bus_prev = {lcd_rs, lcd_db};
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_strobe = 1'b0;
      repeat (3) @(negedge clk);
      nib_cnt = 0;
      check(busy === 1'b1, "R1", "busy in reset", busy, 1);
      check(lcd_en === 1'b0, "R1", "enable in reset", lcd_en, 0);
      rst_n = 1'b1;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
   endtask

   task automatic expect_nib(input int idx, input logic [3:0] exp,
                             input logic exp_rs, input string req);
      check(nib_log[idx] === exp, req, $sformatf("nibble %0d", idx), nib_log[idx], exp);
      check(rs_log[idx] === exp_rs, "R5", $sformatf("rs of nibble %0d", idx), rs_log[idx], exp_rs);
   endtask

   // strobes a byte, scrambles inputs after the edge, returns busy length
   task automatic send_byte(input logic [7:0] b, input logic rs, output int blen);
      @(negedge clk);
      wr_data = b; wr_rs = rs; wr_strobe = 1'b1;
      @(negedge clk);
      wr_strobe = 1'b0; wr_data = ~b; wr_rs = ~rs;
      blen = 0;
      for (int i = 0; i < 5000 && busy; i++) begin
         blen++;
         @(negedge clk);
      end
   endtask

   task automatic t_init();
      logic [3:0] exp [0:11] = '{4'h3, 4'h3, 4'h3, 4'h2, 4'h2, 4'h8,
                                 4'h0, 4'hC, 4'h0, 4'h1, 4'h0, 4'h6};
      do_reset();
      wait_idle();
      check(busy === 1'b0, "R1", "busy after init", busy, 0);
      check(nib_cnt == 12, "R1", "init nibble count", nib_cnt, 12);
      for (int i = 0; i < 12; i++) expect_nib(i, exp[i], 1'b0, "R1");
   endtask

   task automatic t_cmd_byte();
      int base = nib_cnt;
      int blen;
      send_byte(8'h3C, 1'b0, blen);
      check(nib_cnt == base + 2, "R4", "pulses per byte", nib_cnt - base, 2);
      expect_nib(base, 4'h3, 1'b0, "R4");
      expect_nib(base + 1, 4'hC, 1'b0, "R4");
      check(blen == BUSY_EXP, "R3", "busy length", blen, BUSY_EXP);
   endtask

   task automatic t_data_byte();
      int base = nib_cnt;
      int blen;
      // inputs are inverted right after the strobe edge: R2
      send_byte(8'hA5, 1'b1, blen);
      expect_nib(base, 4'hA, 1'b1, "R2");
      expect_nib(base + 1, 4'h5, 1'b1, "R2");
      check(blen == BUSY_EXP, "R3", "busy length data", blen, BUSY_EXP);
      check(lcd_en === 1'b0, "R3", "enable low when idle", lcd_en, 0);
   endtask

   task automatic t_back_to_back();
      int base = nib_cnt;
      int blen;
      send_byte(8'h0F, 1'b1, blen);
      send_byte(8'hF0, 1'b0, blen);
      expect_nib(base, 4'h0, 1'b1, "R4");
      expect_nib(base + 1, 4'hF, 1'b1, "R4");
      expect_nib(base + 2, 4'hF, 1'b0, "R5");
      expect_nib(base + 3, 4'h0, 1'b0, "R5");
   endtask

   task automatic t_timing();
      check(min_setup >= SETUP + 1, "R6", "setup samples", min_setup, SETUP + 1);
      check(min_hi == PULSE, "R6", "min enable width", min_hi, PULSE);
      check(max_hi == PULSE, "R6", "max enable width", max_hi, PULSE);
      check(chg_hi == 0, "R6", "bus changes while enable high", chg_hi, 0);
      check(rw_bad == 0, "R7", "rw high samples", rw_bad, 0);
   endtask

   task automatic t_strobe_in_init();
      do_reset();
      repeat (100) @(negedge clk);
      check(busy === 1'b1, "R8", "busy during init", busy, 1);
      wr_data = 8'h41; wr_rs = 1'b1; wr_strobe = 1'b1;
      @(negedge clk);
      wr_strobe = 1'b0; wr_data = 8'h00; wr_rs = 1'b0;
      wait_idle();
      check(nib_cnt == 14, "R8", "nibbles incl. held byte", nib_cnt, 14);
      expect_nib(11, 4'h6, 1'b0, "R8");
      expect_nib(12, 4'h4, 1'b1, "R8");
      expect_nib(13, 4'h1, 1'b1, "R8");
   endtask

   initial begin
      t_init();
      t_cmd_byte();
      t_data_byte();
      t_back_to_back();
      t_strobe_in_init();
      t_timing();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule